// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a 16-bit processor fetches next. It takes one instruction at a time, with the address that instruction was fetched from, the three stored condition flags (negative, zero, positive) and the value of the register that the instruction names as a jump base. From these it produces the next program counter together with a one-cycle load strobe. The cases are straight-line flow, a conditional branch whose condition is a flag mask, a jump through a register, and a service call. The service call saves its return address in a fixed link register and reads its target from a vector table in memory.

Instructions arrive on a valid/ready stream. The unit is ready whenever it is not in the middle of a service call. While `in_ready` is low, the producer must hold `in_valid` and the instruction fields steady, and nothing is consumed. Every other instruction completes in one cycle. A service call keeps the unit busy for two further cycles: one for the table read request and one for the returning word. The memory port is a plain request strobe with a fixed latency of one cycle and no handshake.

Top module: `next_pc_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `pc_load`, `mem_req`, `link_we` and `illegal` are 0 and `in_ready` is 1.
- R2: An accepted instruction whose opcode (bits 15:12) is not 0000, 1100 or 1111 produces `pc_load`=1 in the next cycle with `next_pc` = pc+1 modulo 2^16, so xFFFF is followed by x0000.
- R3: Opcode 0000 is a conditional branch. Bits 11, 10 and 9 enable the flags `cc[2]` (negative), `cc[1]` (zero) and `cc[0]` (positive). When any enabled flag is set, `next_pc` = pc+1 plus bits 8:0 sign-extended, modulo 2^16. Otherwise `next_pc` = pc+1. The result appears with `pc_load` one cycle after acceptance.
- R4: A branch mask of 111 always takes the target, and a mask of 000 always gives pc+1, for any flag value.
- R5: Opcode 1100 loads `next_pc` with `base_val` as sampled in the acceptance cycle. `base_sel` shows bits 8:6 of `instr` combinationally, so the register file can supply `base_val`.
- R6: In the cycle after an opcode 1111 is accepted, `mem_req`=1 with `mem_addr` = bits 7:0 zero-extended. In the same cycle `link_we`=1, `link_idx`=7 and `link_data` = pc+1 modulo 2^16, and `pc_load` stays 0.
- R7: For opcode 1111, `mem_rdata` is sampled in the cycle after `mem_req`, and in the cycle after that `pc_load`=1 with `next_pc` equal to that word.
- R8: `in_ready` is 0 from the cycle after an opcode 1111 is accepted up to and including the cycle before its `pc_load`. An instruction offered in that window is not consumed until `in_ready` returns to 1.
- R9: Opcode 1101 is reserved. It behaves as in R2, and `illegal` is 1 in exactly its `pc_load` cycle. `illegal` is 0 in every other cycle.
- R10: `pc_load` pulses exactly once for every accepted instruction and is 0 otherwise. `link_we` pulses only for opcode 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the offered instruction |
| cc | input | 3 | Stored flags: bit 2 negative, bit 1 zero, bit 0 positive |
| base_sel | output | 3 | Register index for the jump base (instr bits 8:6) |
| base_val | input | 16 | Value of the register named by `base_sel` |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | 16 | Vector table address |
| mem_rdata | input | 16 | Table word, valid one cycle after `mem_req` |
| next_pc | output | 16 | Next program counter, valid with `pc_load` |
| pc_load | output | 1 | One-cycle strobe to load `next_pc` |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 3 | Link register index (always 7) |
| link_data | output | 16 | Return address |
| illegal | output | 1 | Reserved opcode seen, with its `pc_load` |

## Verification
The bound checker watches timing and relations between ports on every cycle. It checks the one-cycle load after each non-service acceptance, the sequential, jump and fixed-mask branch targets, the table request and link write that follow a service call, the two-cycle gap to the vectored load, the busy window, operand stability under back-pressure, and that `illegal` only appears with a load. The bench's reference model, with its scenarios, is what shows the remaining behaviour. This covers branch resolution across every mask and flag pairing, sign-extended offsets that wrap past x0000 or xFFFF, and the vectored PC matching the exact table word that was requested. It also covers whether a second instruction waiting behind a service call is taken once and only once.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int OPCODE_W = 4;

  localparam logic [OPCODE_W-1:0] OPC_BRANCH = 4'b0000;
  localparam logic [OPCODE_W-1:0] OPC_JUMP   = 4'b1100;
  localparam logic [OPCODE_W-1:0] OPC_RSVD   = 4'b1101;
  localparam logic [OPCODE_W-1:0] OPC_SVC    = 4'b1111;

  // Control classification of one instruction
  typedef struct packed {
    logic is_br;
    logic is_jmp;
    logic is_svc;
    logic is_rsv;
  } ctl_t;

  // Service-call sequencing
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_RESP = 2'd2
  } phase_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int XLEN      = 16,
  parameter int OP_LSB    = 12,
  parameter int NFLAG     = 3,
  parameter int BR_OFF_W  = 9,
  parameter int VEC_W     = 8,
  parameter int REG_IDX_W = 3,
  parameter int BASE_LSB  = 6
) (
  input  logic [XLEN-1:0]      instr,
  output ctl_t                 ctl,
  output logic [NFLAG-1:0]     mask,
  output logic [XLEN-1:0]      br_off,
  output logic [XLEN-1:0]      vec_addr,
  output logic [REG_IDX_W-1:0] base_sel
);

  localparam int SEXT_W = XLEN - BR_OFF_W;
  localparam int ZEXT_W = XLEN - VEC_W;

  logic [OPCODE_W-1:0] opcode;

  assign opcode = instr[XLEN-1:OP_LSB];

  always_comb begin
    ctl        = '0;
    ctl.is_br  = (opcode == OPC_BRANCH);
    ctl.is_jmp = (opcode == OPC_JUMP);
    ctl.is_svc = (opcode == OPC_SVC);
    ctl.is_rsv = (opcode == OPC_RSVD);
  end

  assign mask     = instr[OP_LSB-1 -: NFLAG];
  assign br_off   = {{SEXT_W{instr[BR_OFF_W-1]}}, instr[BR_OFF_W-1:0]};
  assign vec_addr = {{ZEXT_W{1'b0}}, instr[VEC_W-1:0]};
  assign base_sel = instr[BASE_LSB +: REG_IDX_W];

endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int NFLAG = 3
) (
  input  logic             en,
  input  logic [NFLAG-1:0] mask,
  input  logic [NFLAG-1:0] flags,
  output logic             taken
);

  logic [NFLAG-1:0] hit;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    assign hit[gi] = mask[gi] & flags[gi];
  end

  assign taken = en & (|hit);

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] br_off,
  input  logic [XLEN-1:0] base_val,
  input  logic            is_jmp,
  input  logic            taken,
  output logic [XLEN-1:0] npc,
  output logic [XLEN-1:0] link_val
);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;

  assign seq_pc   = pc + XLEN'(1);
  assign br_pc    = seq_pc + br_off;
  assign link_val = seq_pc;

  always_comb begin
    if (is_jmp)     npc = base_val;
    else if (taken) npc = br_pc;
    else            npc = seq_pc;
  end

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int XLEN      = 16,
  parameter int NFLAG     = 3,
  parameter int REG_IDX_W = 3,
  parameter int LINK_REG  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [XLEN-1:0]      instr,
  input  logic [XLEN-1:0]      pc,
  input  logic [NFLAG-1:0]     cc,
  output logic [REG_IDX_W-1:0] base_sel,
  input  logic [XLEN-1:0]      base_val,
  output logic                 mem_req,
  output logic [XLEN-1:0]      mem_addr,
  input  logic [XLEN-1:0]      mem_rdata,
  output logic [XLEN-1:0]      next_pc,
  output logic                 pc_load,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]      link_data,
  output logic                 illegal
);

  localparam int OP_LSB = XLEN - OPCODE_W;

  ctl_t             ctl;
  logic [NFLAG-1:0] mask;
  logic [XLEN-1:0]  br_off;
  logic [XLEN-1:0]  vec_addr;
  logic             taken;
  logic [XLEN-1:0]  npc_comb;
  logic [XLEN-1:0]  link_val;
  logic             accept;
  phase_e           phase;

  npc_decode #(
    .XLEN(XLEN), .OP_LSB(OP_LSB), .NFLAG(NFLAG), .BR_OFF_W(9),
    .VEC_W(8), .REG_IDX_W(REG_IDX_W), .BASE_LSB(6)
  ) u_decode (
    .instr(instr), .ctl(ctl), .mask(mask), .br_off(br_off),
    .vec_addr(vec_addr), .base_sel(base_sel)
  );

  npc_cond #(.NFLAG(NFLAG)) u_cond (
    .en(ctl.is_br), .mask(mask), .flags(cc), .taken(taken)
  );

  npc_target #(.XLEN(XLEN)) u_target (
    .pc(pc), .br_off(br_off), .base_val(base_val), .is_jmp(ctl.is_jmp),
    .taken(taken), .npc(npc_comb), .link_val(link_val)
  );

  assign in_ready = (phase == PH_IDLE);
  assign accept   = in_valid & in_ready;
  assign link_idx = REG_IDX_W'(LINK_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      pc_load   <= 1'b0;
      next_pc   <= '0;
      illegal   <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      pc_load <= 1'b0;
      illegal <= 1'b0;
      mem_req <= 1'b0;
      link_we <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (ctl.is_svc) begin
              phase     <= PH_REQ;
              mem_req   <= 1'b1;
              mem_addr  <= vec_addr;
              link_we   <= 1'b1;
              link_data <= link_val;
            end else begin
              pc_load <= 1'b1;
              next_pc <= npc_comb;
              illegal <= ctl.is_rsv;
            end
          end
        end
        PH_REQ:  phase <= PH_RESP;
        PH_RESP: begin
          phase   <= PH_IDLE;
          pc_load <= 1'b1;
          next_pc <= mem_rdata;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/npc_checker.sv
module npc_checker #(
  parameter int XLEN  = 16,
  parameter int NFLAG = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [XLEN-1:0]  instr,
  input logic [XLEN-1:0]  pc,
  input logic [NFLAG-1:0] cc,
  input logic [XLEN-1:0]  base_val,
  input logic             mem_req,
  input logic [XLEN-1:0]  mem_addr,
  input logic [XLEN-1:0]  mem_rdata,
  input logic [XLEN-1:0]  next_pc,
  input logic             pc_load,
  input logic             link_we,
  input logic [XLEN-1:0]  link_data,
  input logic             illegal
);

  logic            acc;
  logic [3:0]      op;
  logic [XLEN-1:0] seq;
  logic [XLEN-1:0] tgt;
  logic            plain;

  assign acc   = in_valid && in_ready;
  assign op    = instr[XLEN-1 -: 4];
  assign seq   = pc + XLEN'(1);
  assign tgt   = seq + {{(XLEN-9){instr[8]}}, instr[8:0]};
  assign plain = (op != 4'b0000) && (op != 4'b1100) && (op != 4'b1111);

  assert_seq_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && plain |=> pc_load && next_pc == $past(seq));

  assert_br_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'b0000 && (instr[11:9] & cc) == 3'b000 |=> pc_load && next_pc == $past(seq));

  assert_br_always_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'b0000 && instr[11:9] == 3'b111 |=> pc_load && next_pc == $past(tgt));

  assert_jump_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'b1100 |=> pc_load && next_pc == $past(base_val));

  assert_svc_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'b1111 |=> mem_req && link_we && !pc_load &&
      link_data == $past(seq) && mem_addr == {{(XLEN-8){1'b0}}, $past(instr[7:0])});

  assert_svc_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ##2 (pc_load && next_pc == $past(mem_rdata)));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> in_valid && $stable(instr));

  assert_illegal_with_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> pc_load);

  assert_link_only_svc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> mem_req);

  assert_no_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> !pc_load || $past(!in_ready));

endmodule

bind next_pc_unit npc_checker #(.XLEN(XLEN), .NFLAG(NFLAG)) u_npc_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .instr(instr), .pc(pc), .cc(cc), .base_val(base_val), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata), .next_pc(next_pc),
  .pc_load(pc_load), .link_we(link_we), .link_data(link_data), .illegal(illegal)
);

// File: tb/next_pc_unit_bench.sv
`timescale 1ns/1ps
module next_pc_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] instr = '0;
  logic [15:0] pc = '0;
  logic [2:0]  cc = 3'b010;
  logic [2:0]  base_sel;
  logic [15:0] base_val = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = 16'hBAD0;
  logic [15:0] next_pc;
  logic        pc_load;
  logic        link_we;
  logic [2:0]  link_idx;
  logic [15:0] link_data;
  logic        illegal;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  next_pc_unit u_next_pc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .pc(pc), .cc(cc), .base_sel(base_sel), .base_val(base_val),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .next_pc(next_pc), .pc_load(pc_load), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data), .illegal(illegal)
  );

  function automatic logic [15:0] table_word(input logic [15:0] a);
    return {a[7:0], ~a[7:0]} ^ 16'h1234;
  endfunction

  // vector table memory: fixed one-cycle latency
  always @(posedge clk) begin
    if (mem_req) mem_rdata <= table_word(mem_addr);
    else         mem_rdata <= 16'hBAD0;
  end

  // behavioural reference model
  int          m_phase = 0;
  logic [15:0] m_vec = '0;
  logic        e_load = 0, e_req = 0, e_link = 0, e_ill = 0;
  logic [15:0] e_npc = '0, e_addr = '0, e_ldata = '0;
  string       m_tag = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; e_load = 0; e_req = 0; e_link = 0; e_ill = 0;
    end else begin
      e_load = 0; e_req = 0; e_link = 0; e_ill = 0;
      if (m_phase == 0) begin
        if (in_valid) begin
          logic [3:0]  op;
          logic [15:0] s;
          op = instr[15:12];
          s  = pc + 16'd1;
          if (op == 4'hF) begin
            m_phase = 1; e_req = 1; e_link = 1; e_ldata = s;
            m_vec = {8'h00, instr[7:0]}; e_addr = m_vec;
          end else begin
            e_load = 1; e_npc = s; m_tag = "R2";
            if (op == 4'h0) begin
              if ((instr[11:9] & cc) != 3'b000)
                e_npc = s + {{7{instr[8]}}, instr[8:0]};
              m_tag = (instr[11:9] == 3'b000 || instr[11:9] == 3'b111) ? "R4" : "R3";
            end else if (op == 4'hC) begin
              e_npc = base_val; m_tag = "R5";
            end else if (op == 4'hD) begin
              e_ill = 1; m_tag = "R9";
            end
          end
        end
      end else if (m_phase == 1) begin
        m_phase = 2;
      end else begin
        m_phase = 0; e_load = 1; e_npc = table_word(m_vec); m_tag = "R7";
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready === (m_phase == 0), "R8", "in_ready", 16'(in_ready), 16'(m_phase == 0));
      chk(pc_load === e_load, e_load ? m_tag : "R10", "pc_load", 16'(pc_load), 16'(e_load));
      if (e_load) chk(next_pc === e_npc, m_tag, "next_pc", next_pc, e_npc);
      chk(illegal === e_ill, "R9", "illegal", 16'(illegal), 16'(e_ill));
      chk(mem_req === e_req, "R6", "mem_req", 16'(mem_req), 16'(e_req));
      if (e_req) chk(mem_addr === e_addr, "R6", "mem_addr", mem_addr, e_addr);
      chk(link_we === e_link, e_link ? "R6" : "R10", "link_we", 16'(link_we), 16'(e_link));
      if (e_link) begin
        chk(link_data === e_ldata, "R6", "link_data", link_data, e_ldata);
        chk(link_idx === 3'd7, "R6", "link_idx", 16'(link_idx), 16'd7);
      end
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      report();
    end
  end

  task automatic send(input logic [15:0] i, input logic [15:0] p,
                      input logic [2:0] f, input logic [15:0] b);
    @(negedge clk);
    in_valid = 1'b1; instr = i; pc = p; cc = f; base_val = b;
    #1;
    chk(base_sel === i[8:6], "R5", "base_sel", 16'(base_sel), 16'(i[8:6]));
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pc_load && !mem_req && !link_we && !illegal && in_ready, "R1", "reset outputs",
        {11'd0, pc_load, mem_req, link_we, illegal, in_ready}, 16'h0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pc_load && !mem_req && !link_we && !illegal && in_ready, "R1", "after release",
        {11'd0, pc_load, mem_req, link_we, illegal, in_ready}, 16'h0001);

    // R2 sequential and wrap
    send(16'h1042, 16'h3000, 3'b001, 16'h0);
    send(16'h5FFF, 16'hFFFF, 3'b100, 16'h0);
    send(16'h2005, 16'h4000, 3'b010, 16'h0);
    idle(2);
    // R3 conditional branches
    send(16'h0405, 16'h3010, 3'b010, 16'h0);   // z taken, +5
    send(16'h05F0, 16'h3010, 3'b010, 16'h0);   // z taken, negative
    send(16'h0805, 16'h3010, 3'b001, 16'h0);   // n not taken
    send(16'h0210, 16'hFFF8, 3'b001, 16'h0);   // p taken, wraps
    send(16'h0C03, 16'h0001, 3'b100, 16'h0);   // nz with n
    // R4 fixed masks
    send(16'h0E07, 16'h2000, 3'b100, 16'h0);
    send(16'h0FFF, 16'h0000, 3'b001, 16'h0);
    send(16'h0107, 16'h2000, 3'b010, 16'h0);
    send(16'h01FF, 16'hFFFF, 3'b100, 16'h0);
    idle(1);
    // R5 jumps
    send(16'hC1C0, 16'h3000, 3'b010, 16'hABCD);
    send(16'hC080, 16'h3001, 3'b010, 16'h0042);
    // R6 R7 service calls, R8 back-pressure behind them
    send(16'hF021, 16'h3100, 3'b010, 16'h0);
    send(16'hF023, 16'hFFFF, 3'b010, 16'h0);
    send(16'h1234, 16'h3200, 3'b001, 16'h0);
    send(16'hF025, 16'h3300, 3'b100, 16'h0);
    idle(4);
    // R9 reserved opcode
    send(16'hD123, 16'h3400, 3'b010, 16'h0);
    send(16'hDFFF, 16'hFFFF, 3'b010, 16'h0);
    idle(2);
    // mixed stream over all opcodes
    seed = 32'h1F2E3D4C;
    for (int k = 0; k < 200; k++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      send(seed[15:0], seed[31:16], 3'b001 << (seed[20:19] % 3), seed[27:12]);
      if (seed[3:2] == 2'b00) idle(1);
    end
    idle(5);
    report();
  end

endmodule